// File: doc/BRIEF.md
# Pending Write Response Tracker with Completion Gate

This block sits beside a DMA data mover, between the write-issue side and the write-response channel. It keeps a small count of writes that have gone out but whose responses have not come back, and from that count it decides whether the mover may issue another write. Two optional behaviours sit on top of the count. A drain mode throttles issue once the count goes past a fixed cap. It also holds the end-of-descriptor completion back until every response has returned. A strict mode allows only one write in flight at a time.

The mover reports each issued write, each received response and its own end-of-transfer event. The block answers with a write-allowed level, a completion event and an interrupt event. The completion event is either passed straight through or deferred. While a deferred completion drains, the block shows a waiting status. The mover must use that status to hold off fetching the next descriptor and to stop moving data. It may still load the next-descriptor address during that time. A paused status combines the channel's reasons for not moving data: inactive, wait cycles, debug pause, and the cap stall.

Top module: `wgt_top`

## Requirements
- R1: `pend_cnt` rises by one for each cycle with `wr_issue` high and falls by one for each cycle with `wr_resp` high. A cycle with both high leaves it unchanged.
- R2: A response while `pend_cnt` is 0 is ignored and the count stays 0. An issue while the count is at its all-ones value leaves it there.
- R3: `xfer_start` or `chan_reset` high forces `pend_cnt` to 0 at the next clock edge, whatever else is high. After `rst_n` the count is 0, `waiting` is 0 and `wr_allow` is 1.
- R4: With `drain_mode` high, `wr_allow` is 0 whenever `pend_cnt` is above 13. At 13 it is still 1.
- R5: With `strict_mode` high, `wr_allow` is 0 whenever `pend_cnt` is nonzero.
- R6: With `drain_mode` low, `done_evt` is high in the same cycle as `eot`, and `int_evt` is high in that cycle when `irq_en` is also high.
- R7: With `drain_mode` high, an `eot` while `pend_cnt` is nonzero gives no `done_evt`. `waiting` is 1 from the next cycle. `done_evt` rises in the cycle whose response brings the count to 0, and `waiting` is 0 from the cycle after that.
- R8: A deferred `int_evt` fires together with the deferred `done_evt` only if `irq_en` was high in the `eot` cycle. The value of `irq_en` later has no effect.
- R9: `paused` is 1 when any of these holds: `chan_active` is 0, `wait_busy` is 1, `dbg_pause` is 1 while `dbg_pause_dis` is 0, or the R4 cap stall is active.
- R10: With `drain_mode` high, an `eot` while `pend_cnt` is 0 produces `done_evt` in the same cycle, and `waiting` stays 0.
- R11: `wr_allow` is 0 while `waiting` is 1. A `chan_reset` while waiting clears `waiting` at the next edge and no `done_evt` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_reset | input | 1 | Channel reset: clears count and waiting state |
| xfer_start | input | 1 | Start of a new transfer: clears count |
| drain_mode | input | 1 | Enables the cap stall and deferred completion |
| strict_mode | input | 1 | One write in flight at a time |
| wr_issue | input | 1 | A write was issued this cycle |
| wr_resp | input | 1 | A write response arrived this cycle |
| eot | input | 1 | Mover finished the data of the current descriptor |
| irq_en | input | 1 | Descriptor requests an interrupt on completion |
| chan_active | input | 1 | Channel active bit |
| wait_busy | input | 1 | Mover is burning wait cycles |
| dbg_pause | input | 1 | External debug pause |
| dbg_pause_dis | input | 1 | Ignore the debug pause |
| wr_allow | output | 1 | Mover may issue a write this cycle |
| done_evt | output | 1 | Descriptor completion event (sets the end flag) |
| int_evt | output | 1 | Interrupt event for the descriptor |
| waiting | output | 1 | Draining outstanding responses before completion |
| paused | output | 1 | Channel is not moving data |
| pend_cnt | output | CNT_W | Writes awaiting a response |

## Verification
The bench builds the block with its defaults: a 4-bit count, a cap of 13 and strict mode present. With these values a burst of 14 issues reaches the cap stall. In the modes without the cap, the count can be driven to 15, which exercises saturation. The random phase reaches the deferred drain, interrupt capture and the same-cycle issue and response case many times over.

// File: rtl/wgt_pkg.sv
package wgt_pkg;
   // mode bits that steer the issue gate
   typedef struct packed {
      logic drain;
      logic strict;
   } wgt_mode_t;
endpackage

// File: rtl/wgt_counter.sv
module wgt_counter #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             issue,
   input  logic             resp,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_next
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic inc, dec;

   assign inc = issue && (cnt != CNT_MAX);
   assign dec = resp && (cnt != '0);

   always_comb begin
      cnt_next = cnt;
      if (clr)
         cnt_next = '0;
      else if (inc && !dec)
         cnt_next = cnt + CNT_W'(1);
      else if (dec && !inc)
         cnt_next = cnt - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_next;
   end
endmodule

// File: rtl/wgt_issue_gate.sv
module wgt_issue_gate
   import wgt_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int CAP        = 13,
   parameter bit HAS_STRICT = 1'b1
) (
   input  logic [CNT_W-1:0] cnt,
   input  wgt_mode_t        mode,
   input  logic             waiting,
   output logic             cap_stall,
   output logic             wr_allow
);
   localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAP);

   logic strict_block;

   assign cap_stall = mode.drain && (cnt > CAP_V);

   generate
      if (HAS_STRICT) begin : g_strict
         assign strict_block = mode.strict && (cnt != '0);
      end else begin : g_nostrict
         assign strict_block = 1'b0;
      end
   endgenerate

   assign wr_allow = !(cap_stall || strict_block || waiting);
endmodule

// File: rtl/wgt_complete.sv
module wgt_complete #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             drain_mode,
   input  logic             eot,
   input  logic             irq_en,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cnt_next,
   output logic             waiting,
   output logic             done_evt,
   output logic             int_evt
);
   logic irq_held;
   logic now_done, drain_done, defer;

   assign now_done   = eot && !waiting && (!drain_mode || (cnt == '0));
   assign defer      = eot && !waiting && drain_mode && (cnt != '0);
   assign drain_done = waiting && !clr && (cnt_next == '0);

   assign done_evt = now_done || drain_done;
   assign int_evt  = (now_done && irq_en) || (drain_done && irq_held);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         waiting  <= 1'b0;
         irq_held <= 1'b0;
      end else if (clr || drain_done) begin
         waiting  <= 1'b0;
         irq_held <= 1'b0;
      end else if (defer) begin
         waiting  <= 1'b1;
         irq_held <= irq_en;
      end
   end
endmodule

// File: rtl/wgt_top.sv
module wgt_top
   import wgt_pkg::*;
#(
   parameter int CNT_W      = 4,
   parameter int CAP        = 13,
   parameter bit HAS_STRICT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_reset,
   input  logic             xfer_start,
   input  logic             drain_mode,
   input  logic             strict_mode,
   input  logic             wr_issue,
   input  logic             wr_resp,
   input  logic             eot,
   input  logic             irq_en,
   input  logic             chan_active,
   input  logic             wait_busy,
   input  logic             dbg_pause,
   input  logic             dbg_pause_dis,
   output logic             wr_allow,
   output logic             done_evt,
   output logic             int_evt,
   output logic             waiting,
   output logic             paused,
   output logic [CNT_W-1:0] pend_cnt
);
   localparam int CNT_TOP = (1 << CNT_W) - 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("wgt_top: CNT_W out of range");
      end
      if (CAP < 1 || CAP >= CNT_TOP) begin : g_bad_cap
         $error("wgt_top: CAP must leave headroom below the count limit");
      end
   endgenerate

   logic             clr;
   logic             cap_stall;
   logic [CNT_W-1:0] cnt_next;
   wgt_mode_t        mode;

   assign clr  = chan_reset || xfer_start;
   assign mode = '{drain: drain_mode, strict: strict_mode};

   wgt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .issue    (wr_issue),
      .resp     (wr_resp),
      .cnt      (pend_cnt),
      .cnt_next (cnt_next)
   );

   wgt_issue_gate #(.CNT_W(CNT_W), .CAP(CAP), .HAS_STRICT(HAS_STRICT)) u_gate (
      .cnt       (pend_cnt),
      .mode      (mode),
      .waiting   (waiting),
      .cap_stall (cap_stall),
      .wr_allow  (wr_allow)
   );

   wgt_complete #(.CNT_W(CNT_W)) u_cpl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .drain_mode (drain_mode),
      .eot        (eot),
      .irq_en     (irq_en),
      .cnt        (pend_cnt),
      .cnt_next   (cnt_next),
      .waiting    (waiting),
      .done_evt   (done_evt),
      .int_evt    (int_evt)
   );

   assign paused = !chan_active || wait_busy || (dbg_pause && !dbg_pause_dis) || cap_stall;
endmodule

// File: rtl/wgt_checker.sv
module wgt_checker #(
   parameter int CNT_W      = 4,
   parameter int CAP        = 13,
   parameter bit HAS_STRICT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chan_reset,
   input logic             xfer_start,
   input logic             drain_mode,
   input logic             strict_mode,
   input logic             wr_issue,
   input logic             wr_resp,
   input logic             eot,
   input logic             wr_allow,
   input logic             done_evt,
   input logic             waiting,
   input logic [CNT_W-1:0] pend_cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CAP_V   = CNT_W'(CAP);

   logic clr;
   assign clr = chan_reset || xfer_start;

   // R1
   cnt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_issue && !wr_resp && !clr && pend_cnt != CNT_MAX) |=> pend_cnt == $past(pend_cnt) + CNT_W'(1));

   // R1
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_issue && wr_resp && !clr && pend_cnt != '0 && pend_cnt != CNT_MAX) |=> $stable(pend_cnt));

   // R2
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_resp && !wr_issue && !clr && pend_cnt == '0) |=> pend_cnt == '0);

   // R3
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> pend_cnt == '0);

   // R4
   cap_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_mode && pend_cnt > CAP_V) |-> !wr_allow);

   // R5
   strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_STRICT && strict_mode && pend_cnt != '0) |-> !wr_allow);

   // R6
   passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!drain_mode && eot && !waiting) |-> done_evt);

   // R7
   defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_mode && eot && !waiting && !clr && pend_cnt != '0) |-> !done_evt ##1 waiting);

   // R11
   wait_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |-> !wr_allow);

   // R11
   reset_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_reset |=> !waiting);
endmodule

bind wgt_top wgt_checker #(.CNT_W(CNT_W), .CAP(CAP), .HAS_STRICT(HAS_STRICT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .chan_reset  (chan_reset),
   .xfer_start  (xfer_start),
   .drain_mode  (drain_mode),
   .strict_mode (strict_mode),
   .wr_issue    (wr_issue),
   .wr_resp     (wr_resp),
   .eot         (eot),
   .wr_allow    (wr_allow),
   .done_evt    (done_evt),
   .waiting     (waiting),
   .pend_cnt    (pend_cnt)
);

// File: tb/wgt_top_test.sv
`timescale 1ns/1ps
module wgt_top_test;
   localparam int CNT_W = 4;
   localparam int CAP   = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_reset = 0, xfer_start = 0, drain_mode = 0, strict_mode = 0;
   logic wr_issue = 0, wr_resp = 0, eot = 0, irq_en = 0;
   logic chan_active = 1, wait_busy = 0, dbg_pause = 0, dbg_pause_dis = 0;
   logic wr_allow, done_evt, int_evt, waiting, paused;
   logic [CNT_W-1:0] pend_cnt;

   int vectors = 0;
   int errors  = 0;

   // bench model state
   int  m_cnt  = 0;
   bit  m_wait = 0;
   bit  m_ien  = 0;

   always #10 clk = ~clk;

   wgt_top uut (
      .clk(clk), .rst_n(rst_n), .chan_reset(chan_reset), .xfer_start(xfer_start),
      .drain_mode(drain_mode), .strict_mode(strict_mode), .wr_issue(wr_issue),
      .wr_resp(wr_resp), .eot(eot), .irq_en(irq_en), .chan_active(chan_active),
      .wait_busy(wait_busy), .dbg_pause(dbg_pause), .dbg_pause_dis(dbg_pause_dis),
      .wr_allow(wr_allow), .done_evt(done_evt), .int_evt(int_evt),
      .waiting(waiting), .paused(paused), .pend_cnt(pend_cnt)
   );

   function automatic bit exp_allow_f();
      bit cap, strict;
      cap    = drain_mode && (m_cnt > CAP);
      strict = strict_mode && (m_cnt != 0);
      return !(cap || strict || m_wait);
   endfunction

   function automatic bit exp_paused_f();
      return !chan_active || wait_busy || (dbg_pause && !dbg_pause_dis) ||
             (drain_mode && (m_cnt > CAP));
   endfunction

   task automatic cmp(input string req, input int act, input int exp);
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // one cycle: inputs already set after the falling edge; check then advance model
   task automatic step();
      bit clr, inc, dec, imm, drain;
      int nxt;
      #2;
      vectors++;
      clr = chan_reset || xfer_start;
      inc = wr_issue && (m_cnt != 15);
      dec = wr_resp && (m_cnt != 0);
      nxt = clr ? 0 : m_cnt + int'(inc) - int'(dec);
      imm   = eot && !m_wait && (!drain_mode || m_cnt == 0);
      drain = m_wait && !clr && (nxt == 0);
      cmp("R1/R2/R3 pend_cnt", int'(pend_cnt), m_cnt);
      cmp("R4/R5/R11 wr_allow", int'(wr_allow), int'(exp_allow_f()));
      cmp("R6/R7/R10 done_evt", int'(done_evt), int'(imm || drain));
      cmp("R6/R8 int_evt", int'(int_evt), int'((imm && irq_en) || (drain && m_ien)));
      cmp("R7/R11 waiting", int'(waiting), int'(m_wait));
      cmp("R9 paused", int'(paused), int'(exp_paused_f()));
      if (clr || drain) begin
         m_wait = 0; m_ien = 0;
      end else if (eot && !m_wait && drain_mode && m_cnt != 0) begin
         m_wait = 1; m_ien = irq_en;
      end
      m_cnt = nxt;
      @(negedge clk);
   endtask

   task automatic idle();
      chan_reset = 0; xfer_start = 0; wr_issue = 0; wr_resp = 0; eot = 0;
   endtask

   task automatic issue_n(input int n);
      for (int i = 0; i < n; i++) begin
         idle(); wr_issue = 1; step();
      end
      idle();
   endtask

   task automatic resp_n(input int n);
      for (int i = 0; i < n; i++) begin
         idle(); wr_resp = 1; step();
      end
      idle();
   endtask

   initial begin : watchdog
      #3000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (2) @(negedge clk);
      // R3 reset state checked in the first step before and after release
      rst_n = 1'b1;
      @(negedge clk);
      idle(); step();

      // R1 count up, then simultaneous issue and response holds
      issue_n(3);
      idle(); wr_issue = 1; wr_resp = 1; step();
      resp_n(3);
      // R2 response at zero ignored
      resp_n(2);
      // R2 saturation at all-ones with no cap (drain off)
      issue_n(17);
      // R3 xfer_start clears, with issue also high
      idle(); xfer_start = 1; wr_issue = 1; step();
      idle(); step();

      // R4 cap stall: 13 still allowed, 14 stalls
      drain_mode = 1;
      issue_n(13);
      idle(); step();
      issue_n(1);
      idle(); step();
      // R9 paused due to cap, then each other source
      resp_n(1);
      chan_active = 0; idle(); step(); chan_active = 1;
      wait_busy = 1; step(); wait_busy = 0;
      dbg_pause = 1; step(); dbg_pause_dis = 1; step();
      dbg_pause = 0; dbg_pause_dis = 0;
      resp_n(13);

      // R10 eot at zero in drain mode completes at once
      idle(); eot = 1; irq_en = 1; step(); idle(); step();
      // R7 deferred completion; R8 irq_en captured at eot
      issue_n(3);
      idle(); eot = 1; irq_en = 1; step();
      irq_en = 0; idle(); step();
      resp_n(3);
      idle(); step();
      // R8 captured low, later high ignored
      issue_n(2);
      idle(); eot = 1; irq_en = 0; step();
      irq_en = 1; resp_n(2); idle(); step();
      // R11 channel reset while waiting: no completion
      issue_n(2);
      idle(); eot = 1; step();
      idle(); chan_reset = 1; step();
      idle(); step();

      // R6 pass-through with drain mode off
      drain_mode = 0;
      issue_n(2);
      idle(); eot = 1; irq_en = 1; step();
      idle(); eot = 1; irq_en = 0; step();
      resp_n(2);

      // R5 strict mode: one write in flight
      strict_mode = 1;
      issue_n(1); idle(); step(); resp_n(1); idle(); step();
      strict_mode = 0;

      // constrained random phase across all modes
      for (int i = 0; i < 4000; i++) begin
         idle();
         if (($urandom % 64) == 0) begin
            drain_mode  = $urandom % 2;
            strict_mode = $urandom % 2;
         end
         chan_active   = ($urandom % 16) != 0;
         wait_busy     = ($urandom % 16) == 0;
         dbg_pause     = ($urandom % 16) == 0;
         dbg_pause_dis = $urandom % 2;
         irq_en        = $urandom % 2;
         wr_issue      = exp_allow_f() && (($urandom % 3) != 0);
         wr_resp       = ($urandom % 3) == 0;
         eot           = !m_wait && (($urandom % 24) == 0);
         chan_reset    = ($urandom % 400) == 0;
         xfer_start    = ($urandom % 300) == 0;
         step();
      end
      idle(); step();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule